// File: doc/BRIEF.md
# Floating-Point and Vector Access Permission Checker

This block decides, for one floating-point or vector instruction or one move of a floating-point system register, whether the operation may go ahead. If it may not, the block reports which fault to raise, at which exception level, with which exception class and syndrome. It sees the current exception level and the register width of each higher level. It sees whether the security and virtualization extensions are present and whether the core is in secure state. It also sees the access-control fields of both register widths, the non-secure access overrides, the hypervisor trap fields, the two 64-bit trap bits, the floating-point enable bit and the kind of operation. Instruction decode and exception entry stay with the surrounding pipeline.

A request is presented with a one-cycle strobe. The verdict is registered at that edge. A done pulse marks it one cycle after the strobe, and the verdict then holds until the next request. The control is a two-state machine. `ST_IDLE` waits; the transition *accept* (strobe high) enters `ST_DONE`, which drives the done pulse. From `ST_DONE`, the transition *chain* (strobe high again) stays in `ST_DONE`, and the transition *retire* (strobe low) goes back to `ST_IDLE`.

Top module: `fp_access_check`

## Requirements
- R1: On a cycle with `req_valid` high, the verdict is captured at that clock edge, `done` is high for the following cycle only unless another request arrives, and the outputs hold their value until the next request; reset clears all outputs to zero.
- R2: Fault kind encoding is 0 none, 1 undefined, 2 trap to level 1, 3 trap to level 2, 4 trap to level 3, 5 undefined at level 2; `fault_valid` is high exactly when the kind is not 0, and with no fault the class and syndrome are zero. An undefined fault (kind 1) reports class 0 and syndrome 0.
- R3: The 64-bit check is used when `req_is64` is set, or when the level is 0 and level 1 is 64-bit; at level 0 it faults unless `en_fp64` equals 3, at level 1 unless `en_fp64[0]` is set, giving kind 2 with class 0x07 and syndrome 0x1E00000.
- R4: When the 64-bit enable passes, the level-2 trap bit with virtualization present and the level at most 2 gives kind 3; otherwise the level-3 trap bit with security present gives kind 4; both use class 0x07 and syndrome 0x1E00000.
- R5: On the 32-bit path at any level other than 2, level 0 is undefined unless `acc_cp` equals 3, and levels 1 and 3 are undefined unless `acc_cp[0]` is set; level 2 skips this check.
- R6: A vector operation (`req_op` = 1) with the vector-disable bit set is undefined outside level 2; other operation kinds ignore that bit.
- R7: With security present, level 3 not 64-bit and non-secure state, a set `ns_vdis` acts as a set vector-disable bit and a clear `ns_cp` acts as an access field of zero.
- R8: A clear `fp_en` makes floating-point (0), vector (1) and control-register move (2) operations undefined, but not a privileged move of another system register (3).
- R9: A move of another system register (`req_op` = 3) at level 0 is undefined regardless of every enable field.
- R10: With virtualization present, non-secure state and level 2 not 64-bit, a set `hyp_cp_trap`, or a vector operation with `hyp_vec_trap` set, traps with class 0x08 and syndrome 0x20 for vector or 0xA otherwise; at level 2 the kind is 5, elsewhere 3. Under the R7 conditions a set `ns_vdis` forces the vector trap on and a set `ns_cp` forces the coprocessor trap on.
- R11: With virtualization present, non-secure state and level 2 64-bit, the hypervisor trap fields are replaced by the R4 trap-bit checks.
- R12: On the 32-bit path with no earlier fault, security present and level 3 64-bit, a set `el3_trap` gives kind 4 with class 0x07 and syndrome 0x1E00000.
- R13: Priority on the 32-bit path is access/vector-disable checks, then the enable bit, then hypervisor traps, then the final level-3 check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 FP, 1 vector, 2 control-register move, 3 other system-register move |
| req_is64 | input | 1 | Request issued with 64-bit registers |
| cur_lvl | input | 2 | Current exception level |
| lvl1_is64 | input | 1 | Level 1 uses 64-bit registers |
| lvl2_is64 | input | 1 | Level 2 uses 64-bit registers |
| lvl3_is64 | input | 1 | Level 3 uses 64-bit registers |
| has_sec | input | 1 | Security extension present |
| has_virt | input | 1 | Virtualization extension present |
| is_secure | input | 1 | Core is in secure state |
| en_fp64 | input | 2 | 64-bit FP/vector enable field |
| acc_cp | input | 2 | 32-bit coprocessor access field |
| acc_vdis | input | 1 | 32-bit vector-disable bit |
| ns_cp | input | 1 | Non-secure coprocessor access bit |
| ns_vdis | input | 1 | Non-secure vector-disable bit |
| hyp_cp_trap | input | 1 | Hypervisor coprocessor trap bit |
| hyp_vec_trap | input | 1 | Hypervisor vector trap bit |
| el2_trap | input | 1 | 64-bit level-2 FP trap bit |
| el3_trap | input | 1 | 64-bit level-3 FP trap bit |
| fp_en | input | 1 | Floating-point enable bit |
| done | output | 1 | Verdict ready pulse |
| fault_valid | output | 1 | A fault is reported |
| fault_kind | output | 3 | Fault kind (R2 encoding) |
| fault_ec | output | 6 | Exception class |
| fault_syn | output | 25 | Syndrome |

## Verification
The bench aims at the places where the paths meet. Level 0 under a 64-bit level 1 must take the 64-bit field even when the 32-bit field would pass; a design that missed this lets user code run. Level 2 must skip the 32-bit access check and report a hypervisor trap as kind 5, not kind 3, and the non-secure overrides must apply only when level 3 is 32-bit. Priority cases, where an undefined condition and a trap, or a hypervisor trap and the level-3 bit, are both set, expose a design whose checks run in the wrong order; it would report the wrong level and syndrome.

// File: rtl/fpchk_pkg.sv
package fpchk_pkg;

    localparam int LVL_W = 2;
    localparam int EC_W  = 6;
    localparam int SYN_W = 25;

    localparam logic [EC_W-1:0]  EC_FP_ACCESS = 6'h07;
    localparam logic [EC_W-1:0]  EC_CTL_TRAP  = 6'h08;
    localparam logic [SYN_W-1:0] SYN_ACCESS64 = 25'h1E00000;
    localparam logic [SYN_W-1:0] SYN_HYP_VEC  = 25'h0000020;
    localparam logic [SYN_W-1:0] SYN_HYP_FP   = 25'h000000A;

    typedef enum logic [2:0] {
        FK_NONE     = 3'd0,
        FK_UNDEF    = 3'd1,
        FK_TRAP1    = 3'd2,
        FK_TRAP2    = 3'd3,
        FK_TRAP3    = 3'd4,
        FK_UNDEF_L2 = 3'd5
    } fault_e;

    typedef enum logic [1:0] {
        OP_FP       = 2'd0,
        OP_VEC      = 2'd1,
        OP_MOVE_CTL = 2'd2,
        OP_MOVE_SYS = 2'd3
    } op_e;

    typedef struct packed {
        fault_e           kind;
        logic [EC_W-1:0]  ec;
        logic [SYN_W-1:0] syn;
    } verdict_t;

    function automatic verdict_t mk_verdict(fault_e k, logic [EC_W-1:0] ec,
                                            logic [SYN_W-1:0] syn);
        verdict_t v;
        v.kind = k;
        v.ec   = ec;
        v.syn  = syn;
        return v;
    endfunction

    function automatic verdict_t no_fault();
        return mk_verdict(FK_NONE, '0, '0);
    endfunction

    function automatic verdict_t undef_fault();
        return mk_verdict(FK_UNDEF, '0, '0);
    endfunction

endpackage

// File: rtl/fpchk_trap_chain.sv
module fpchk_trap_chain
    import fpchk_pkg::*;
(
    input  logic [LVL_W-1:0] lvl,
    input  logic             has_virt,
    input  logic             has_sec,
    input  logic             el2_trap,
    input  logic             el3_trap,
    output verdict_t         v
);

    localparam logic [LVL_W-1:0] LVL_HYP = LVL_W'(2);

    always_comb begin
        v = no_fault();
        if (has_virt && (lvl <= LVL_HYP) && el2_trap) begin
            v = mk_verdict(FK_TRAP2, EC_FP_ACCESS, SYN_ACCESS64);
        end else if (has_sec && el3_trap) begin
            v = mk_verdict(FK_TRAP3, EC_FP_ACCESS, SYN_ACCESS64);
        end
    end

endmodule

// File: rtl/fpchk_path64.sv
module fpchk_path64
    import fpchk_pkg::*;
(
    input  logic [LVL_W-1:0] lvl,
    input  logic [1:0]       en_fp64,
    input  logic             has_virt,
    input  logic             has_sec,
    input  logic             el2_trap,
    input  logic             el3_trap,
    output verdict_t         v
);

    verdict_t chain_v;
    logic     lvl_block;

    fpchk_trap_chain u_chain (
        .lvl      (lvl),
        .has_virt (has_virt),
        .has_sec  (has_sec),
        .el2_trap (el2_trap),
        .el3_trap (el3_trap),
        .v        (chain_v)
    );

    always_comb begin
        lvl_block = 1'b0;
        if (lvl == LVL_W'(0))      lvl_block = (en_fp64 != 2'b11);
        else if (lvl == LVL_W'(1)) lvl_block = !en_fp64[0];
        v = lvl_block ? mk_verdict(FK_TRAP1, EC_FP_ACCESS, SYN_ACCESS64)
                      : chain_v;
    end

endmodule

// File: rtl/fpchk_path32.sv
module fpchk_path32
    import fpchk_pkg::*;
(
    input  logic [LVL_W-1:0] lvl,
    input  logic             is_vec,
    input  logic             en_check,
    input  logic             lvl2_is64,
    input  logic             lvl3_is64,
    input  logic             has_sec,
    input  logic             has_virt,
    input  logic             is_secure,
    input  logic [1:0]       acc_cp,
    input  logic             acc_vdis,
    input  logic             ns_cp,
    input  logic             ns_vdis,
    input  logic             hyp_cp_trap,
    input  logic             hyp_vec_trap,
    input  logic             el2_trap,
    input  logic             el3_trap,
    input  logic             fp_en,
    output verdict_t         v
);

    verdict_t   chain_v;
    logic       ns_view;
    logic       eff_vdis;
    logic [1:0] eff_cp;
    logic       eff_hcp;
    logic       eff_hvec;
    logic       access_bad;

    fpchk_trap_chain u_chain (
        .lvl      (lvl),
        .has_virt (has_virt),
        .has_sec  (has_sec),
        .el2_trap (el2_trap),
        .el3_trap (el3_trap),
        .v        (chain_v)
    );

    // Non-secure view of the access and trap fields
    always_comb begin
        ns_view  = has_sec && !lvl3_is64 && !is_secure;
        eff_vdis = acc_vdis | (ns_view & ns_vdis);
        eff_cp   = (ns_view && !ns_cp) ? 2'b00 : acc_cp;
        eff_hvec = hyp_vec_trap | (ns_view & ns_vdis);
        eff_hcp  = hyp_cp_trap | (ns_view & ns_cp);
        if (lvl == LVL_W'(0)) access_bad = (eff_cp != 2'b11);
        else                  access_bad = !eff_cp[0];
    end

    // Ordered checks; the first that fires wins
    always_comb begin
        v = no_fault();
        if ((lvl != LVL_W'(2)) && ((is_vec && eff_vdis) || access_bad)) begin
            v = undef_fault();
        end else if (en_check && !fp_en) begin
            v = undef_fault();
        end else if (has_virt && !is_secure && lvl2_is64) begin
            v = chain_v;
        end else if (has_virt && !is_secure && ((is_vec && eff_hvec) || eff_hcp)) begin
            v = mk_verdict((lvl == LVL_W'(2)) ? FK_UNDEF_L2 : FK_TRAP2, EC_CTL_TRAP,
                           is_vec ? SYN_HYP_VEC : SYN_HYP_FP);
        end else if (has_sec && lvl3_is64 && el3_trap) begin
            v = mk_verdict(FK_TRAP3, EC_FP_ACCESS, SYN_ACCESS64);
        end
    end

endmodule

// File: rtl/fp_access_check.sv
module fp_access_check
    import fpchk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic             req_is64,
    input  logic [LVL_W-1:0] cur_lvl,
    input  logic             lvl1_is64,
    input  logic             lvl2_is64,
    input  logic             lvl3_is64,
    input  logic             has_sec,
    input  logic             has_virt,
    input  logic             is_secure,
    input  logic [1:0]       en_fp64,
    input  logic [1:0]       acc_cp,
    input  logic             acc_vdis,
    input  logic             ns_cp,
    input  logic             ns_vdis,
    input  logic             hyp_cp_trap,
    input  logic             hyp_vec_trap,
    input  logic             el2_trap,
    input  logic             el3_trap,
    input  logic             fp_en,
    output logic             done,
    output logic             fault_valid,
    output logic [2:0]       fault_kind,
    output logic [EC_W-1:0]  fault_ec,
    output logic [SYN_W-1:0] fault_syn
);

    typedef enum logic {ST_IDLE, ST_DONE} state_e;

    state_e   state_q, state_d;
    verdict_t v64, v32, verdict;
    op_e      op;
    logic     use64;

    assign op = op_e'(req_op);

    fpchk_path64 u_path64 (
        .lvl      (cur_lvl),
        .en_fp64  (en_fp64),
        .has_virt (has_virt),
        .has_sec  (has_sec),
        .el2_trap (el2_trap),
        .el3_trap (el3_trap),
        .v        (v64)
    );

    fpchk_path32 u_path32 (
        .lvl          (cur_lvl),
        .is_vec       (op == OP_VEC),
        .en_check     (op != OP_MOVE_SYS),
        .lvl2_is64    (lvl2_is64),
        .lvl3_is64    (lvl3_is64),
        .has_sec      (has_sec),
        .has_virt     (has_virt),
        .is_secure    (is_secure),
        .acc_cp       (acc_cp),
        .acc_vdis     (acc_vdis),
        .ns_cp        (ns_cp),
        .ns_vdis      (ns_vdis),
        .hyp_cp_trap  (hyp_cp_trap),
        .hyp_vec_trap (hyp_vec_trap),
        .el2_trap     (el2_trap),
        .el3_trap     (el3_trap),
        .fp_en        (fp_en),
        .v            (v32)
    );

    always_comb begin
        use64 = req_is64 || ((cur_lvl == LVL_W'(0)) && lvl1_is64);
        if ((op == OP_MOVE_SYS) && (cur_lvl == LVL_W'(0))) verdict = undef_fault();
        else if (use64)                                   verdict = v64;
        else                                              verdict = v32;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid)  state_d = ST_DONE;  // accept
            ST_DONE: if (!req_valid) state_d = ST_IDLE;  // retire (else chain)
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_valid <= 1'b0;
            fault_kind  <= '0;
            fault_ec    <= '0;
            fault_syn   <= '0;
        end else if (req_valid) begin
            fault_valid <= (verdict.kind != FK_NONE);
            fault_kind  <= verdict.kind;
            fault_ec    <= verdict.ec;
            fault_syn   <= verdict.syn;
        end
    end

    assign done = (state_q == ST_DONE);

    p_done_after_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> done);

    p_hold_when_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(fault_kind) && $stable(fault_syn) && $stable(fault_ec)));

    p_clean_no_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_kind == 3'd0) |-> (fault_ec == '0 && fault_syn == '0 && !fault_valid));

    p_trap1_fields_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_kind == 3'd2) |-> (fault_syn == SYN_ACCESS64 && fault_ec == EC_FP_ACCESS));

    p_user_sysmove_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd3 && cur_lvl == LVL_W'(0)) |=> (fault_kind == 3'd1));

    p_l2_undef_syn_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_kind == 3'd5) |-> (fault_ec == EC_CTL_TRAP &&
                                  (fault_syn == SYN_HYP_VEC || fault_syn == SYN_HYP_FP)));

endmodule

// File: tb/fp_access_check_bench.sv
module fp_access_check_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic        req_is64 = 1'b0;
    logic [1:0]  cur_lvl = 2'd1;
    logic        lvl1_is64 = 1'b0, lvl2_is64 = 1'b0, lvl3_is64 = 1'b0;
    logic        has_sec = 1'b0, has_virt = 1'b0, is_secure = 1'b1;
    logic [1:0]  en_fp64 = 2'd3, acc_cp = 2'd3;
    logic        acc_vdis = 1'b0, ns_cp = 1'b1, ns_vdis = 1'b0;
    logic        hyp_cp_trap = 1'b0, hyp_vec_trap = 1'b0;
    logic        el2_trap = 1'b0, el3_trap = 1'b0, fp_en = 1'b1;
    logic        done, fault_valid;
    logic [2:0]  fault_kind;
    logic [5:0]  fault_ec;
    logic [24:0] fault_syn;

    int checks = 0;
    int fails  = 0;

    localparam int K_NONE = 0, K_UNDEF = 1, K_T1 = 2, K_T2 = 3, K_T3 = 4, K_UL2 = 5;
    localparam int EC_A = 7, EC_H = 8;
    localparam int S64 = 32'h1E00000, S_VEC = 32'h20, S_FP = 32'hA;

    always #10 clk = ~clk;

    fp_access_check u_fp_access_check (.*);

    task automatic base();
        req_op = 2'd0; req_is64 = 1'b0; cur_lvl = 2'd1;
        lvl1_is64 = 1'b0; lvl2_is64 = 1'b0; lvl3_is64 = 1'b0;
        has_sec = 1'b0; has_virt = 1'b0; is_secure = 1'b1;
        en_fp64 = 2'd3; acc_cp = 2'd3; acc_vdis = 1'b0; ns_cp = 1'b1; ns_vdis = 1'b0;
        hyp_cp_trap = 1'b0; hyp_vec_trap = 1'b0; el2_trap = 1'b0; el3_trap = 1'b0;
        fp_en = 1'b1;
    endtask

    task automatic expect_out(string tag, int k, int ec, int syn, logic dn);
        checks++;
        if (fault_kind !== k[2:0] || fault_ec !== ec[5:0] || fault_syn !== syn[24:0] ||
            fault_valid !== (k != 0) || done !== dn) begin
            fails++;
            $display("FAIL %s: kind=%0d ec=%0h syn=%0h valid=%0b done=%0b expected kind=%0d ec=%0h syn=%0h done=%0b",
                     tag, fault_kind, fault_ec, fault_syn, fault_valid, done, k, ec, syn, dn);
        end
    endtask

    task automatic try_req(string tag, int k, int ec, int syn);
        @(negedge clk); req_valid = 1'b1;
        @(negedge clk); req_valid = 1'b0;
        expect_out(tag, k, ec, syn, 1'b1);
    endtask

    task automatic t_reset();
        expect_out("R1 reset", K_NONE, 0, 0, 1'b0);
    endtask

    task automatic t_timing();
        base(); try_req("R2 all enabled", K_NONE, 0, 0);
        base(); acc_cp = 2'd0; try_req("R1 fault capture", K_UNDEF, 0, 0);
        acc_cp = 2'd3;
        @(negedge clk); expect_out("R1 hold after done", K_UNDEF, 0, 0, 1'b0);
    endtask

    task automatic t_path64();
        base(); req_is64 = 1; cur_lvl = 0; en_fp64 = 1; try_req("R3 lvl0 field 1", K_T1, EC_A, S64);
        en_fp64 = 3; try_req("R3 lvl0 field 3", K_NONE, 0, 0);
        cur_lvl = 1; en_fp64 = 1; try_req("R3 lvl1 bit0", K_NONE, 0, 0);
        en_fp64 = 2; try_req("R3 lvl1 field 2", K_T1, EC_A, S64);
        base(); cur_lvl = 0; lvl1_is64 = 1; en_fp64 = 0;
        try_req("R3 lvl0 under 64-bit lvl1", K_T1, EC_A, S64);
    endtask

    task automatic t_chain64();
        base(); req_is64 = 1; has_virt = 1; has_sec = 1; el2_trap = 1; el3_trap = 1;
        try_req("R4 lvl2 bit first", K_T2, EC_A, S64);
        base(); req_is64 = 1; cur_lvl = 3; has_virt = 1; el2_trap = 1;
        try_req("R4 lvl3 ignores lvl2 bit", K_NONE, 0, 0);
        has_sec = 1; el2_trap = 0; el3_trap = 1;
        try_req("R4 lvl3 bit", K_T3, EC_A, S64);
    endtask

    task automatic t_access32();
        base(); cur_lvl = 0; acc_cp = 1; try_req("R5 lvl0 field 1", K_UNDEF, 0, 0);
        cur_lvl = 1; try_req("R5 lvl1 field 1", K_NONE, 0, 0);
        acc_cp = 2; try_req("R5 lvl1 field 2", K_UNDEF, 0, 0);
        cur_lvl = 2; acc_cp = 0; try_req("R5 lvl2 skips", K_NONE, 0, 0);
    endtask

    task automatic t_vdis();
        base(); acc_vdis = 1; req_op = 1; try_req("R6 vector disabled", K_UNDEF, 0, 0);
        req_op = 0; try_req("R6 FP ignores vector disable", K_NONE, 0, 0);
    endtask

    task automatic t_ns_override();
        base(); has_sec = 1; is_secure = 0; ns_cp = 0;
        try_req("R7 ns cp clears access", K_UNDEF, 0, 0);
        is_secure = 1; try_req("R7 secure keeps access", K_NONE, 0, 0);
        base(); has_sec = 1; is_secure = 0; ns_vdis = 1; req_op = 1;
        try_req("R7 ns vector disable", K_UNDEF, 0, 0);
        lvl3_is64 = 1; try_req("R7 no override with 64-bit lvl3", K_NONE, 0, 0);
    endtask

    task automatic t_enable();
        base(); fp_en = 0; try_req("R8 FP enable clear", K_UNDEF, 0, 0);
        req_op = 2; try_req("R8 ctl move enable clear", K_UNDEF, 0, 0);
        req_op = 3; try_req("R8 sys move skips enable", K_NONE, 0, 0);
    endtask

    task automatic t_sysmove();
        base(); cur_lvl = 0; req_op = 3; try_req("R9 user sys move", K_UNDEF, 0, 0);
        req_op = 2; try_req("R9 user ctl move allowed", K_NONE, 0, 0);
    endtask

    task automatic t_hyp();
        base(); has_virt = 1; is_secure = 0; hyp_cp_trap = 1;
        try_req("R10 cp trap FP", K_T2, EC_H, S_FP);
        req_op = 1; try_req("R10 cp trap vector", K_T2, EC_H, S_VEC);
        req_op = 0; cur_lvl = 2; try_req("R10 lvl2 undefined", K_UL2, EC_H, S_FP);
        base(); has_virt = 1; is_secure = 0; hyp_vec_trap = 1;
        try_req("R10 vector trap ignored for FP", K_NONE, 0, 0);
        base(); has_virt = 1; has_sec = 1; is_secure = 0;
        try_req("R10 ns cp forces trap", K_T2, EC_H, S_FP);
        base(); has_virt = 1; is_secure = 1; hyp_cp_trap = 1;
        try_req("R10 secure no trap", K_NONE, 0, 0);
    endtask

    task automatic t_lvl2_64();
        base(); has_virt = 1; is_secure = 0; lvl2_is64 = 1; hyp_cp_trap = 1;
        try_req("R11 fields replaced", K_NONE, 0, 0);
        el2_trap = 1; try_req("R11 lvl2 bit", K_T2, EC_A, S64);
    endtask

    task automatic t_final3();
        base(); has_sec = 1; lvl3_is64 = 1; el3_trap = 1;
        try_req("R12 lvl3 bit", K_T3, EC_A, S64);
        lvl3_is64 = 0; try_req("R12 32-bit lvl3 ignores", K_NONE, 0, 0);
    endtask

    task automatic t_priority();
        base(); has_virt = 1; is_secure = 0; hyp_cp_trap = 1; acc_cp = 0;
        try_req("R13 undefined before hyp trap", K_UNDEF, 0, 0);
        base(); has_virt = 1; has_sec = 1; is_secure = 0; lvl3_is64 = 1;
        hyp_cp_trap = 1; el3_trap = 1;
        try_req("R13 hyp trap before lvl3", K_T2, EC_H, S_FP);
        base(); fp_en = 0; has_sec = 1; lvl3_is64 = 1; el3_trap = 1;
        try_req("R13 enable before lvl3", K_UNDEF, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        base();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_timing();
        t_path64();
        t_chain64();
        t_access32();
        t_vdis();
        t_ns_override();
        t_enable();
        t_sysmove();
        t_hyp();
        t_lvl2_64();
        t_final3();
        t_priority();
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule